// File: doc/BRIEF.md
# Segmented DAC Row-Column Decoder

This block is the digital front end of a 16-bit segmented current-steering converter. A binary sample word is registered on the sample clock. Its six upper bits are then turned into enables for an 8x8 grid of equal unary current cells. Its ten lower bits pass through as enables for binary-weighted current switches.

The upper field is split into two halves. Its top three bits form a row code and its lower three bits form a column code. Each half goes through its own small thermometer decoder. Every grid cell then merges one or two row lines and one column line with a local gate. The grid fills row by row, in row-major order. The grid has 64 positions and 63 cells, so the last position stays permanently off.

All 63 unary enables and all 10 binary enables leave the block from one register stage. Both sections therefore change on the same clock edge, and the total latency is two clock cycles.

Top module: `segdac_rowcol_decoder`

## Requirements
- R1: The outputs reflect the input sampled two rising clock edges earlier: one input register stage and one output register stage.
- R2: `binary_en[k]` equals bit k of the delayed input code, for k from 0 to 9.
- R3: The number of set bits in `unary_en` equals the value of input bits [15:10].
- R4: Unary cells fill in row-major order. Bit `row*8+col` of `unary_en` belongs to the grid cell at that row and column. For a 6-bit value n, exactly bits 0 to n-1 are set. A value that is a multiple of 8 enables only whole rows.
- R5: An all-zero input code drives every unary and binary enable low.
- R6: An all-ones input code drives all 63 unary enables and all 10 binary enables high.
- R7: A synchronous active-high reset clears every output enable to zero on the next rising edge.
- R8: Over a complete ramp through all 65536 codes, the count of enabled unary cells times 1024, plus the value of `binary_en`, equals the delayed input code at every step.
- R9: A change confined to input bits [9:0] leaves `unary_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | 16 | Binary sample code |
| unary_en | output | 63 | Unary cell switch enables, index row*8+col |
| binary_en | output | 10 | Binary-weighted switch enables |

## Verification
The hardest situations to reach are the row boundaries. At these codes the partial-row term of the local gate hands over to the full-row term, for example 7 to 8 and 55 to 56 in the upper field. They are also where a mis-indexed row line or column line would go unnoticed at most other codes. The bench streams every one of the 65536 codes back to back, one per clock. It therefore crosses each boundary with every lower-field value and also exercises the pipeline at full rate. Directed vectors sit exactly on the boundaries and check the bit-exact fill pattern, not just the cell count.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

    // Width of each half (row or column) of the unary field
    localparam int HALF_W   = 3;
    // Width of the binary-weighted field
    localparam int LSB_W    = 10;
    localparam int UNARY_W  = 2 * HALF_W;
    localparam int CODE_W   = UNARY_W + LSB_W;
    localparam int GRID     = 1 << HALF_W;
    localparam int CELLS    = GRID * GRID - 1;

    // Field view of a registered sample word
    typedef struct packed {
        logic [HALF_W-1:0] row;
        logic [HALF_W-1:0] col;
        logic [LSB_W-1:0]  lsb;
    } sample_t;

    // Linear enable index of a grid position, row-major
    function automatic int cell_index(input int r, input int c);
        return r * GRID + c;
    endfunction

endpackage

// File: rtl/segdac_in_reg.sv
module segdac_in_reg
    import segdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_d,
    output sample_t           code_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else begin
            code_q <= sample_t'(code_d);
        end
    end

endmodule

// File: rtl/segdac_thermo.sv
module segdac_thermo #(
    parameter int IN_W  = 3,
    localparam int OUT_W = (1 << IN_W) - 1
) (
    input  logic [IN_W-1:0]  bin,
    output logic [OUT_W-1:0] therm
);

    // Line k is high when the code exceeds k
    for (genvar k = 0; k < OUT_W; k++) begin : g_line
        assign therm[k] = (32'(bin) > k);
    end

endmodule

// File: rtl/segdac_unit_gate.sv
module segdac_unit_gate (
    input  logic row_full,
    input  logic row_part,
    input  logic col_on,
    output logic cell_on
);

    // Cell is on when its row is completely filled, or when its row is the
    // partially filled one and its column is covered
    assign cell_on = row_full | (row_part & col_on);

endmodule

// File: rtl/segdac_cell_grid.sv
module segdac_cell_grid
    import segdac_pkg::*;
#(
    parameter int H_W = HALF_W,
    localparam int G   = 1 << H_W,
    localparam int TW  = G - 1,
    localparam int NC  = G * G - 1
) (
    input  logic [TW-1:0] row_th,
    input  logic [TW-1:0] col_th,
    output logic [NC-1:0] cell_en
);

    // row_ext[r+1]: row r fully filled; row_ext[r]: row r at least partly reached
    logic [G:0]   row_ext;
    logic [G-1:0] col_ext;

    assign row_ext = {1'b0, row_th, 1'b1};
    assign col_ext = {1'b0, col_th};

    for (genvar r = 0; r < G; r++) begin : g_row
        for (genvar c = 0; c < G; c++) begin : g_col
            if (r * G + c < NC) begin : g_cell
                segdac_unit_gate i_gate (
                    .row_full (row_ext[r+1]),
                    .row_part (row_ext[r]),
                    .col_on   (col_ext[c]),
                    .cell_on  (cell_en[r*G+c])
                );
            end
        end
    end

endmodule

// File: rtl/segdac_rowcol_decoder.sv
module segdac_rowcol_decoder
    import segdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    output logic [CELLS-1:0]  unary_en,
    output logic [LSB_W-1:0]  binary_en
);

    localparam int TW = GRID - 1;

    sample_t          code_q;
    logic [TW-1:0]    row_th;
    logic [TW-1:0]    col_th;
    logic [CELLS-1:0] cell_en;

    segdac_in_reg i_in_reg (
        .clk    (clk),
        .rst    (rst),
        .code_d (code_in),
        .code_q (code_q)
    );

    segdac_thermo #(.IN_W(HALF_W)) i_row_dec (
        .bin   (code_q.row),
        .therm (row_th)
    );

    segdac_thermo #(.IN_W(HALF_W)) i_col_dec (
        .bin   (code_q.col),
        .therm (col_th)
    );

    segdac_cell_grid #(.H_W(HALF_W)) i_grid (
        .row_th  (row_th),
        .col_th  (col_th),
        .cell_en (cell_en)
    );

    // Both sections leave through the same register edge
    always_ff @(posedge clk) begin
        if (rst) begin
            unary_en  <= '0;
            binary_en <= '0;
        end else begin
            unary_en  <= cell_en;
            binary_en <= code_q.lsb;
        end
    end

endmodule

// File: rtl/segdac_rowcol_checker.sv
module segdac_rowcol_checker
    import segdac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] code_in,
    input logic [CELLS-1:0]  unary_en,
    input logic [LSB_W-1:0]  binary_en
);

    // Two-stage shadow of the input word
    logic [CODE_W-1:0] s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= code_in;
            s2 <= s1;
        end
    end

    // R2
    binary_pass_chk: assert property (@(posedge clk) disable iff (rst)
        binary_en == s2[LSB_W-1:0]);

    // R3
    unary_count_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(unary_en) == int'(s2[CODE_W-1:LSB_W]));

    // R4
    unary_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (unary_en & (unary_en + 1'b1)) == '0);

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (unary_en == '0 && binary_en == '0));

    // R8
    weighted_sum_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(unary_en) * (1 << LSB_W) + int'(binary_en)) == int'(s2));

endmodule

bind segdac_rowcol_decoder segdac_rowcol_checker i_rowcol_chk (
    .clk       (clk),
    .rst       (rst),
    .code_in   (code_in),
    .unary_en  (unary_en),
    .binary_en (binary_en)
);

// File: tb/test_segdac_rowcol_decoder.sv
`timescale 1ns/1ps
module test_segdac_rowcol_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] code_in = '0;
    logic [62:0] unary_en;
    logic [9:0]  binary_en;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    segdac_rowcol_decoder i_segdac_rowcol_decoder (
        .clk       (clk),
        .rst       (rst),
        .code_in   (code_in),
        .unary_en  (unary_en),
        .binary_en (binary_en)
    );

    // Vector: code and expected number of lit unary cells
    localparam int NV = 12;
    localparam logic [15:0] VEC_CODE [NV] = '{
        16'h0000, 16'hFFFF, 16'h0400, 16'h03FF, 16'h1C00, 16'h2000,
        16'h2400, 16'hDC00, 16'hE000, 16'hFC00, 16'h5555, 16'hAAAA};
    localparam int VEC_CNT [NV] = '{
        0, 63, 1, 0, 7, 8, 9, 55, 56, 63, 21, 42};

    function automatic logic [62:0] fill_mask(input int n);
        logic [63:0] m;
        m = (64'd1 << n) - 64'd1;
        return m[62:0];
    endfunction

    task automatic check_out(input string req, input logic [62:0] eu, input logic [9:0] eb);
        n_run++;
        if (unary_en !== eu || binary_en !== eb) begin
            n_fail++;
            $display("FAIL %s: unary=%h binary=%h expected unary=%h binary=%h",
                     req, unary_en, binary_en, eu, eb);
        end
    endtask

    task automatic apply(input logic [15:0] c);
        @(negedge clk) code_in = c;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7 reset state
        check_out("R7 reset state", '0, '0);
        rst = 1'b0;

        // R1 R2 R3 R4 R5 R6: table of vectors
        for (int i = 0; i < NV; i++) begin
            apply(VEC_CODE[i]);
            check_out($sformatf("R1/R2/R3/R4 vector %0d", i),
                      fill_mask(VEC_CNT[i]), VEC_CODE[i][9:0]);
        end

        // R5 all zeros
        apply(16'h0000);
        check_out("R5 all zeros", '0, '0);

        // R6 all ones
        apply(16'hFFFF);
        check_out("R6 all ones", {63{1'b1}}, {10{1'b1}});

        // R1 latency: one edge after a change the output still holds the old code
        @(negedge clk) code_in = 16'h2400;
        @(posedge clk);
        @(negedge clk);
        check_out("R1 one-edge hold", {63{1'b1}}, {10{1'b1}});
        @(posedge clk);
        @(negedge clk);
        check_out("R1 two-edge update", fill_mask(9), 10'h000);

        // R9 low-field change leaves unary unchanged
        apply(16'h5400);
        check_out("R9 before lsb change", fill_mask(21), 10'h000);
        apply(16'h57FF);
        check_out("R9 after lsb change", fill_mask(21), 10'h3FF);

        // R7 synchronous reset clears loaded outputs
        apply(16'hFFFF);
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_out("R7 reset clears", '0, '0);
        rst = 1'b0;
        code_in = 16'h0000;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);

        // R8 full ramp streamed one code per clock
        for (int i = 0; i < 65536 + 2; i++) begin
            if (i >= 2) begin
                int cnt;
                int sum;
                cnt = $countones(unary_en);
                sum = cnt * 1024 + int'(binary_en);
                n_run++;
                if (sum != i - 2 || unary_en !== fill_mask((i - 2) >> 10)) begin
                    n_fail++;
                    $display("FAIL R8 ramp step %0d: sum=%0d unary=%h expected sum=%0d unary=%h",
                             i - 2, sum, unary_en, i - 2, fill_mask((i - 2) >> 10));
                end
            end
            code_in = (i < 65536) ? 16'(i) : 16'h0000;
            @(negedge clk);
        end

        finish_run();
    end

endmodule